// File: doc/BRIEF.md
# Network Time-of-Day Clock with Fine Frequency Trim

This block keeps the time of day for packet timestamping. It runs from a fixed reference clock and holds a 32-bit seconds count, a 32-bit nanoseconds count and a 32-bit sub-nanosecond residue. On every reference clock edge the residue accumulates a nominal step of `BASE_NS` nanoseconds, raised or lowered by a signed trim value. Carries out of the residue move the nanoseconds count, and the nanoseconds count rolls into the seconds count.

Software reaches the clock through a small word-addressed register port. Reading the residue word freezes a copy of the full time, so that the nanoseconds and seconds words read afterwards always match each other. Writing the nanoseconds word and then the seconds word sets the clock. A strobe from the transmit path captures the current time into a held stamp. An interrupt output collects sticky event causes through a mask.

Register word map (`regAddr`): 0 residue, 1 nanoseconds, 2 seconds, 3 trim, 4 cause, 5 mask, 6 transmit stamp nanoseconds, 7 transmit stamp seconds.

Top module: `ptp_clock_top`

## Requirements
- R1: After reset the trim, cause, mask and transmit stamp registers read 0, `irqOut` is low, and the residue reads 0 while the trim is 0.
- R2: With a trim of 0, the nanoseconds count gains exactly `BASE_NS` (default 8) on each clock edge and the residue stays 0.
- R3: The trim word (address 3) holds a sign in bit 31 and a magnitude in bits 30:0, in units of 2^-32 ns. On each edge the residue gains `BASE_NS`·2^32 plus the magnitude when the sign is 0, or minus the magnitude when the sign is 1. The carry out of bit 31 of the residue adds to the nanoseconds count. The word reads back as written.
- R4: When the nanoseconds count would reach or pass `NS_PER_SEC` (default 1,000,000,000), it takes the excess instead and the seconds count increments.
- R5: A read of address 0 freezes the nanoseconds and seconds values present before that edge. Reads of address 1 and address 2 return that frozen copy, however many cycles later they come, until address 0 is read again.
- R6: A write to address 1 stages the nanoseconds value. A later write to address 2 loads the staged nanoseconds and the written seconds on that edge and clears the residue. Time then advances from the loaded value on the following edges.
- R7: A seconds count wrap from 0xFFFFFFFF to 0 sets cause bit 0.
- R8: A `txStampStrobe` pulse while no stamp is held stores the time into addresses 6 (ns) and 7 (s) and sets cause bit 1. Strobes that arrive while a stamp is held are ignored. A read of address 7 releases the stamp.
- R9: Cause bits (address 4) are sticky and are cleared by writing 1 to them; writing 0 has no effect. Mask bits (address 5) exist at positions 0, 1 and 3 to 6. Bit 2 reads 0. `irqOut` is high exactly when some cause bit and its mask bit are both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rstN | input | 1 | Active-low synchronous reset |
| regAddr | input | 3 | Register word select |
| regWrEn | input | 1 | Write strobe |
| regWrData | input | 32 | Write data |
| regRdEn | input | 1 | Read strobe; side effects take place on the edge |
| regRdData | output | 32 | Read data for `regAddr`, combinational |
| txStampStrobe | input | 1 | Transmit-path capture request |
| irqOut | output | 1 | Masked time-sync interrupt |

## Verification
The hardest state to reach is the seconds wrap. From reset it would take about 2^32 seconds of ticking. The bench gets there by loading 0xFFFFFFFF seconds and a nanoseconds value one step below the limit, so a single edge must roll both counts and raise cause bit 0. The trim accumulation is checked across a sweep of signed magnitudes and tick counts. Each case loads a known time first, so the expected residue and nanoseconds follow from a 64-bit product formed in the bench.

// File: rtl/ptpclk_pkg.sv
package ptpclk_pkg;
  localparam int ADDR_W  = 3;
  localparam int RES_W   = 32;
  localparam int ADJ_W   = 31;
  localparam int CAUSE_W = 7;
  localparam int CB_SECWRAP = 0;
  localparam int CB_TXSTAMP = 1;
  // cause bits with a source inside this block
  localparam logic [CAUSE_W-1:0] CAUSE_IMPL = 7'b0000011;
  // mask bits that are stored
  localparam logic [CAUSE_W-1:0] MASK_IMPL  = 7'b1111011;

  typedef enum logic [ADDR_W-1:0] {
    REG_RES = 3'd0, REG_NS = 3'd1, REG_SEC = 3'd2, REG_INC = 3'd3,
    REG_CAUSE = 3'd4, REG_MASK = 3'd5, REG_TXLO = 3'd6, REG_TXHI = 3'd7
  } regSel_e;

  typedef struct packed {
    logic        loadTime;
    logic        takeSnap;
    logic        captureTx;
    logic [31:0] loadNs;
    logic [31:0] loadSec;
  } dpCtl_t;
endpackage

// File: rtl/ptp_time_datapath.sv
module ptp_time_datapath
  import ptpclk_pkg::*;
#(
  parameter int BASE_NS    = 8,
  parameter int NS_PER_SEC = 1_000_000_000
) (
  input  logic             clk,
  input  logic             rstN,
  input  dpCtl_t           ctl,
  input  logic             adjNeg,
  input  logic [ADJ_W-1:0] adjMag,
  output logic [RES_W-1:0] residue,
  output logic [31:0]      nsNow,
  output logic [31:0]      secNow,
  output logic [31:0]      snapNs,
  output logic [31:0]      snapSec,
  output logic [31:0]      txNs,
  output logic [31:0]      txSec,
  output logic             secWrapEv
);
  localparam int CARRY_W = $clog2(BASE_NS + 2) + 1;
  localparam int STEP_W  = RES_W + CARRY_W;
  localparam logic [STEP_W-1:0] BASE_STEP = STEP_W'(BASE_NS) << RES_W;
  localparam logic [32:0] NS_LIM = 33'(NS_PER_SEC);

  logic [STEP_W-1:0] step;
  logic [STEP_W-1:0] accSum;
  logic [32:0]       nsSum;
  logic              rollover;

  always_comb begin
    step      = adjNeg ? (BASE_STEP - STEP_W'(adjMag)) : (BASE_STEP + STEP_W'(adjMag));
    accSum    = STEP_W'(residue) + step;
    nsSum     = {1'b0, nsNow} + 33'(accSum[STEP_W-1:RES_W]);
    rollover  = (nsSum >= NS_LIM);
    secWrapEv = rollover && (secNow == 32'hFFFF_FFFF) && !ctl.loadTime;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      residue <= '0;
      nsNow   <= '0;
      secNow  <= '0;
    end else if (ctl.loadTime) begin
      residue <= '0;
      nsNow   <= ctl.loadNs;
      secNow  <= ctl.loadSec;
    end else begin
      residue <= accSum[RES_W-1:0];
      if (rollover) begin
        nsNow  <= 32'(nsSum - NS_LIM);
        secNow <= secNow + 32'd1;
      end else begin
        nsNow  <= nsSum[31:0];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      snapNs  <= '0;
      snapSec <= '0;
      txNs    <= '0;
      txSec   <= '0;
    end else begin
      if (ctl.takeSnap) begin
        snapNs  <= nsNow;
        snapSec <= secNow;
      end
      if (ctl.captureTx) begin
        txNs  <= nsNow;
        txSec <= secNow;
      end
    end
  end
endmodule

// File: rtl/ptp_reg_ctrl.sv
module ptp_reg_ctrl
  import ptpclk_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic [ADDR_W-1:0]  regAddr,
  input  logic               regWrEn,
  input  logic [31:0]        regWrData,
  input  logic               regRdEn,
  input  logic               txStampStrobe,
  input  logic               secWrapEv,
  input  logic [RES_W-1:0]   residue,
  input  logic [31:0]        snapNs,
  input  logic [31:0]        snapSec,
  input  logic [31:0]        txNs,
  input  logic [31:0]        txSec,
  output dpCtl_t             ctl,
  output logic               adjNeg,
  output logic [ADJ_W-1:0]   adjMag,
  output logic [31:0]        regRdData,
  output logic               irqOut,
  output logic [CAUSE_W-1:0] causeReg,
  output logic [CAUSE_W-1:0] maskReg,
  output logic               txValid
);
  regSel_e sel;
  logic [31:0] pendNs;
  logic [CAUSE_W-1:0] causeSet, causeClr;

  assign sel = regSel_e'(regAddr);

  always_comb begin
    ctl.loadTime  = regWrEn && (sel == REG_SEC);
    ctl.takeSnap  = regRdEn && (sel == REG_RES);
    ctl.captureTx = txStampStrobe && !txValid;
    ctl.loadNs    = pendNs;
    ctl.loadSec   = regWrData;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pendNs  <= '0;
      adjNeg  <= 1'b0;
      adjMag  <= '0;
      maskReg <= '0;
      txValid <= 1'b0;
    end else begin
      if (regWrEn && sel == REG_NS)   pendNs  <= regWrData;
      if (regWrEn && sel == REG_INC)  {adjNeg, adjMag} <= regWrData;
      if (regWrEn && sel == REG_MASK) maskReg <= regWrData[CAUSE_W-1:0] & MASK_IMPL;
      if (regRdEn && sel == REG_TXHI) txValid <= 1'b0;
      else if (ctl.captureTx)         txValid <= 1'b1;
    end
  end

  always_comb begin
    causeSet             = '0;
    causeSet[CB_SECWRAP] = secWrapEv;
    causeSet[CB_TXSTAMP] = ctl.captureTx;
    causeClr = (regWrEn && sel == REG_CAUSE) ? regWrData[CAUSE_W-1:0] : '0;
  end

  for (genvar b = 0; b < CAUSE_W; b++) begin : g_cause
    if (CAUSE_IMPL[b]) begin : g_src
      always_ff @(posedge clk) begin
        if (!rstN) causeReg[b] <= 1'b0;
        else       causeReg[b] <= causeSet[b] | (causeReg[b] & ~causeClr[b]);
      end
    end else begin : g_none
      assign causeReg[b] = 1'b0;
    end
  end

  assign irqOut = |(causeReg & maskReg);

  always_comb begin
    case (sel)
      REG_RES:   regRdData = residue;
      REG_NS:    regRdData = snapNs;
      REG_SEC:   regRdData = snapSec;
      REG_INC:   regRdData = {adjNeg, adjMag};
      REG_CAUSE: regRdData = 32'(causeReg);
      REG_MASK:  regRdData = 32'(maskReg);
      REG_TXLO:  regRdData = txNs;
      default:   regRdData = txSec;
    endcase
  end
endmodule

// File: rtl/ptp_clock_top.sv
module ptp_clock_top
  import ptpclk_pkg::*;
#(
  parameter int BASE_NS    = 8,
  parameter int NS_PER_SEC = 1_000_000_000
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic [2:0]  regAddr,
  input  logic        regWrEn,
  input  logic [31:0] regWrData,
  input  logic        regRdEn,
  output logic [31:0] regRdData,
  input  logic        txStampStrobe,
  output logic        irqOut
);
  dpCtl_t             ctl;
  logic               adjNeg;
  logic [ADJ_W-1:0]   adjMag;
  logic [RES_W-1:0]   residue;
  logic [31:0]        nsNow, secNow, snapNs, snapSec, txNs, txSec;
  logic               secWrapEv, txValid;
  logic [CAUSE_W-1:0] causeReg, maskReg;

  ptp_reg_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWrEn(regWrEn),
    .regWrData(regWrData), .regRdEn(regRdEn), .txStampStrobe(txStampStrobe),
    .secWrapEv(secWrapEv), .residue(residue), .snapNs(snapNs), .snapSec(snapSec),
    .txNs(txNs), .txSec(txSec), .ctl(ctl), .adjNeg(adjNeg), .adjMag(adjMag),
    .regRdData(regRdData), .irqOut(irqOut), .causeReg(causeReg),
    .maskReg(maskReg), .txValid(txValid)
  );

  ptp_time_datapath #(.BASE_NS(BASE_NS), .NS_PER_SEC(NS_PER_SEC)) uDp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .adjNeg(adjNeg), .adjMag(adjMag),
    .residue(residue), .nsNow(nsNow), .secNow(secNow), .snapNs(snapNs),
    .snapSec(snapSec), .txNs(txNs), .txSec(txSec), .secWrapEv(secWrapEv)
  );
endmodule

// File: rtl/ptp_clock_checker.sv
module ptp_clock_checker
  import ptpclk_pkg::*;
#(
  parameter int NS_PER_SEC = 1_000_000_000
) (
  input logic               clk,
  input logic               rstN,
  input logic [2:0]         regAddr,
  input logic               regWrEn,
  input logic [31:0]        regWrData,
  input logic               regRdEn,
  input logic               txStampStrobe,
  input logic [RES_W-1:0]   residue,
  input logic [31:0]        nsNow,
  input logic [31:0]        secNow,
  input logic [31:0]        snapNs,
  input logic [31:0]        snapSec,
  input logic [31:0]        txNs,
  input logic [31:0]        txSec,
  input logic               txValid,
  input logic [CAUSE_W-1:0] causeReg
);
  logic wrSec, rdRes, rdHi, clrWrap;
  assign wrSec   = regWrEn && regAddr == 3'(REG_SEC);
  assign rdRes   = regRdEn && regAddr == 3'(REG_RES);
  assign rdHi    = regRdEn && regAddr == 3'(REG_TXHI);
  assign clrWrap = regWrEn && regAddr == 3'(REG_CAUSE) && regWrData[0];

  AST_NS_BELOW_LIMIT: assert property (@(posedge clk) disable iff (!rstN)
    !wrSec |=> nsNow < 32'(NS_PER_SEC)); // R4
  AST_TIME_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    wrSec |=> (secNow == $past(regWrData)) && (residue == '0)); // R6
  AST_TIME_FORWARD: assert property (@(posedge clk) disable iff (!rstN)
    (!wrSec && secNow != 32'hFFFF_FFFF) |=>
      (secNow > $past(secNow)) || (secNow == $past(secNow) && nsNow >= $past(nsNow))); // R2
  AST_SNAP_HELD: assert property (@(posedge clk) disable iff (!rstN)
    !rdRes |=> $stable(snapNs) && $stable(snapSec)); // R5
  AST_TX_HELD: assert property (@(posedge clk) disable iff (!rstN)
    (txValid && !rdHi) |=> txValid && $stable(txNs) && $stable(txSec)); // R8
  AST_TX_RELEASE: assert property (@(posedge clk) disable iff (!rstN)
    rdHi |=> !txValid); // R8
  AST_WRAP_CAUSE: assert property (@(posedge clk) disable iff (!rstN)
    (secNow == 32'hFFFF_FFFF && !wrSec) |=> (secNow != '0) || causeReg[0]); // R7
  AST_CAUSE_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (causeReg[0] && !clrWrap) |=> causeReg[0]); // R9
endmodule

bind ptp_clock_top ptp_clock_checker #(.NS_PER_SEC(NS_PER_SEC)) uChk (.*);

// File: tb/ptp_clock_top_test.sv
`timescale 1ns/1ps
module ptp_clock_top_test;
  localparam int BASE = 8;
  localparam int LIM  = 1_000_000_000;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [2:0]  regAddr = '0;
  logic        regWrEn = 1'b0;
  logic [31:0] regWrData = '0;
  logic        regRdEn = 1'b0;
  logic [31:0] regRdData;
  logic        txStampStrobe = 1'b0;
  logic        irqOut;

  int checks = 0;
  int errors = 0;
  logic [31:0] rv;

  always #5 clk = ~clk;

  ptp_clock_top uut (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWrEn(regWrEn),
    .regWrData(regWrData), .regRdEn(regRdEn), .regRdData(regRdData),
    .txStampStrobe(txStampStrobe), .irqOut(irqOut)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  // read issued in the current cycle; side effect lands on the next edge
  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    regRdEn = 1'b1; regAddr = a;
    #1 d = regRdData;
    @(negedge clk);
    regRdEn = 1'b0;
  endtask

  task automatic setTime(input logic [31:0] s, input logic [31:0] n);
    wr(3'd1, n);
    wr(3'd2, s);
  endtask

  task automatic pulseTx();
    txStampStrobe = 1'b1;
    @(negedge clk);
    txStampStrobe = 1'b0;
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] mags [5] = '{32'd0, 32'd1, 32'h0001_2345, 32'h3FFF_FFFF, 32'h7FFF_FFFF};
    int delays [3] = '{1, 5, 13};
    logic [31:0] held;

    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 irq", {31'd0, irqOut}, 32'd0);
    rd(3'd0, rv); check("R1 residue", rv, 32'd0);
    rd(3'd3, rv); check("R1 trim", rv, 32'd0);
    rd(3'd4, rv); check("R1 cause", rv, 32'd0);
    rd(3'd5, rv); check("R1 mask", rv, 32'd0);
    rd(3'd6, rv); check("R1 tx lo", rv, 32'd0);
    rd(3'd7, rv); check("R1 tx hi", rv, 32'd0);

    // R2 plain ticking, R6 load
    for (int d = 0; d < 6; d++) begin
      setTime(32'd100 + 32'(d), 32'd1000);
      repeat (d) @(negedge clk);
      rd(3'd0, rv); check("R2 residue", rv, 32'd0);
      rd(3'd1, rv); check("R6 ns after load", rv, 32'd1000 + 32'(BASE * d));
      rd(3'd2, rv); check("R6 sec after load", rv, 32'd100 + 32'(d));
    end

    // R3 trim sweep
    for (int sgn = 0; sgn < 2; sgn++) begin
      for (int m = 0; m < 5; m++) begin
        for (int k = 0; k < 3; k++) begin
          logic [63:0] stepV, total;
          wr(3'd3, {sgn[0], mags[m][30:0]});
          rd(3'd3, rv); check("R3 trim readback", rv, {sgn[0], mags[m][30:0]});
          stepV = sgn ? ((64'(BASE) << 32) - 64'(mags[m][30:0]))
                      : ((64'(BASE) << 32) + 64'(mags[m][30:0]));
          total = stepV * 64'(delays[k]);
          setTime(32'd9, 32'd1000);
          repeat (delays[k]) @(negedge clk);
          rd(3'd0, rv); check("R3 residue", rv, total[31:0]);
          rd(3'd1, rv); check("R3 ns", rv, 32'd1000 + total[63:32]);
        end
      end
    end
    wr(3'd3, 32'd0);

    // R5 frozen snapshot
    setTime(32'd55, 32'd2000);
    rd(3'd0, rv);
    repeat (7) @(negedge clk);
    rd(3'd1, rv); check("R5 frozen ns", rv, 32'd2000);
    repeat (4) @(negedge clk);
    rd(3'd2, rv); check("R5 frozen sec", rv, 32'd55);
    rd(3'd1, rv); check("R5 ns still frozen", rv, 32'd2000);

    // R4 rollover exact and with excess
    setTime(32'd20, 32'(LIM - BASE));
    @(negedge clk);
    rd(3'd0, rv); rd(3'd1, rv); check("R4 ns exact roll", rv, 32'd0);
    rd(3'd2, rv); check("R4 sec exact roll", rv, 32'd21);
    setTime(32'd30, 32'(LIM - 4));
    @(negedge clk);
    rd(3'd0, rv); rd(3'd1, rv); check("R4 ns excess", rv, 32'd4);
    rd(3'd2, rv); check("R4 sec excess", rv, 32'd31);
    rd(3'd4, rv); check("R7 no wrap cause", rv, 32'd0);

    // R7 seconds wrap
    setTime(32'hFFFF_FFFF, 32'(LIM - BASE));
    @(negedge clk);
    rd(3'd0, rv); rd(3'd1, rv); check("R7 ns wrap", rv, 32'd0);
    rd(3'd2, rv); check("R7 sec wrap", rv, 32'd0);
    rd(3'd4, rv); check("R7 cause bit0", rv, 32'd1);
    wr(3'd5, 32'd1);
    check("R9 irq wrap masked in", {31'd0, irqOut}, 32'd1);
    wr(3'd4, 32'd0);
    rd(3'd4, rv); check("R9 write 0 keeps", rv, 32'd1);
    wr(3'd4, 32'd1);
    rd(3'd4, rv); check("R9 w1c clears", rv, 32'd0);
    check("R9 irq low after clear", {31'd0, irqOut}, 32'd0);
    wr(3'd5, 32'h0000_007F);
    rd(3'd5, rv); check("R9 mask bits", rv, 32'h0000_007B);
    wr(3'd5, 32'd0);

    // R8 transmit capture
    setTime(32'd7, 32'd500);
    repeat (3) @(negedge clk);
    pulseTx();
    held = 32'd500 + 32'(3 * BASE);
    rd(3'd6, rv); check("R8 tx lo", rv, held);
    rd(3'd4, rv); check("R8 cause bit1", rv, 32'd2);
    check("R9 irq masked off", {31'd0, irqOut}, 32'd0);
    wr(3'd5, 32'd2);
    check("R9 irq on", {31'd0, irqOut}, 32'd1);
    wr(3'd4, 32'd2);
    check("R9 irq off after w1c", {31'd0, irqOut}, 32'd0);
    repeat (2) @(negedge clk);
    pulseTx();
    rd(3'd6, rv); check("R8 second strobe ignored", rv, held);
    rd(3'd4, rv); check("R8 no new cause", rv, 32'd0);
    rd(3'd7, rv); check("R8 tx hi", rv, 32'd7);
    setTime(32'd12, 32'd800);
    repeat (2) @(negedge clk);
    pulseTx();
    rd(3'd6, rv); check("R8 recapture lo", rv, 32'd800 + 32'(2 * BASE));
    rd(3'd7, rv); check("R8 recapture hi", rv, 32'd12);
    rd(3'd4, rv); check("R8 recapture cause", rv, 32'd2);
    check("R9 irq from recapture", {31'd0, irqOut}, 32'd1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule